// File: doc/BRIEF.md
# UART Receive FIFO with Status Registers

This block is the receive-side buffer of a UART, placed between a byte-level receiver front end and a simple register bus. Each byte the front end delivers is either queued in a circular FIFO (FIFO mode) or loaded into a single holding register (bypass mode). Software drains the data by reading a data register, and every such read has a side effect: it pops the FIFO or clears the ready flag. Status registers report how many bytes are queued, whether a byte is ready, and which line errors have occurred since the last look.

The front end also signals line breaks and per-byte parity and framing errors. Two one-cycle event outputs, one for stored bytes and one for error conditions, feed a separate interrupt block. A write strobe for flushing the transmit FIFO is passed on as a pulse, because the transmit path lives elsewhere. Read data is combinational from the present state. Side effects of a read take place at the clock edge that ends the read cycle. The FIFO depth must be a power of two between 2 and 256.

Top module: `uart_rxq`

## Requirements
- R1: After reset the block is in bypass mode. Reads of the control register (address 0), the transfer status register (address 1), the error status register (address 2) and the FIFO status register (address 3) all return 0.
- R2: In the control register (address 0), bit 0 selects FIFO mode when 1. Writing 1 to bit 1 empties the receive FIFO. Writing 1 to bit 2 drives `tx_flush` high for that one write cycle and leaves the receive FIFO untouched. Bits 1 and 2 always read back as 0.
- R3: The FIFO status register (address 3) holds the stored byte count in bits [7:0] and a full flag in bit 8. When the FIFO is full, the count field reads 0 and bit 8 is set.
- R4: In FIFO mode, a read of the data register (address 4) returns the oldest stored byte and removes it. Bit 0 of the transfer status register (address 1) reads 1 while at least one byte remains.
- R5: In FIFO mode, a read of the data register while the FIFO is empty returns 0, pulses `err_evt`, and leaves the FIFO empty.
- R6: In bypass mode, each incoming byte replaces the holding register and sets transfer status bit 0. A data register read returns the held byte and clears that bit.
- R7: A byte that arrives while the FIFO is full and no pop happens in the same cycle is dropped. The drop pulses `err_evt`, sets error status bit 0, and leaves the FIFO contents and ready bit unchanged.
- R8: `rx_evt` pulses in every cycle in which a byte is stored, either into the FIFO or into the holding register, and stays low when a byte is dropped.
- R9: A break indication stores a 0x00 byte and sets error status bit 3. A byte presented in the same cycle as a break is ignored.
- R10: Error status bits are overrun (bit 0), parity (bit 1), frame (bit 2) and break (bit 3). A read of address 2 returns them and clears them. A flag raised in the same cycle as that read is kept for the next read.
- R11: Writes to addresses 1, 2, 3 and 4 change no state: counts, ready bit, error bits and FIFO contents are unaffected.
- R12: A pop and an incoming byte in the same cycle leave the count unchanged. When the FIFO is full, the incoming byte is accepted into the slot the pop frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; side effects at the closing edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| rx_valid | input | 1 | Front end presents a received byte |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error for the presented byte |
| rx_frm_err | input | 1 | Framing error for the presented byte |
| rx_break | input | 1 | Line break detected |
| rx_evt | output | 1 | Receive interrupt source pulse |
| err_evt | output | 1 | Error interrupt source pulse (overflow or underflow) |
| tx_flush | output | 1 | Transmit FIFO flush pulse |

## Verification
Two pairs of functions can collide in one cycle. A data register read can coincide with an incoming byte. An error status read can coincide with a newly raised line error. The bench drives the read strobe and the front-end strobe together on the same falling edge. For the first pair it checks the popped value, the unchanged count, and the acceptance of the byte into a full FIFO, and it then drains the FIFO to confirm the new byte sits last. For the second pair it checks that the clearing read returns the old flags and that the next read still shows the parity flag raised in the same cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        RG_CTRL  = 3'd0,
        RG_XSTAT = 3'd1,
        RG_ERRS  = 3'd2,
        RG_FSTAT = 3'd3,
        RG_RDATA = 3'd4
    } rxq_reg_e;

    localparam int CTL_EN    = 0;
    localparam int CTL_RXCLR = 1;
    localparam int CTL_TXCLR = 2;

    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;
    localparam int ERR_NB  = 4;

    localparam int FST_FULL = 8;

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       push_i,
    input  logic [DW-1:0]              push_data_i,
    input  logic                       pop_i,
    output logic                       accept_o,
    output logic [DW-1:0]              head_o,
    output logic [$clog2(DEPTH):0]     level_o,
    output logic                       full_o,
    output logic                       empty_o
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL_LVL = (PW+1)'(DEPTH);

    typedef struct packed {
        logic [PW:0] wr;
        logic [PW:0] rd;
    } ptr_t;

    ptr_t q, d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          pop_ok;

    assign level_o = q.wr - q.rd;
    assign full_o  = (level_o == FULL_LVL);
    assign empty_o = (level_o == '0);
    assign pop_ok  = pop_i && !empty_o;
    assign accept_o = push_i && !clr_i && (!full_o || pop_ok);
    assign head_o  = mem_q[q.rd[PW-1:0]];

    always_comb begin
        d = q;
        if (clr_i) begin
            d = '0;
        end else begin
            if (accept_o) d.wr = q.wr + 1'b1;
            if (pop_ok)   d.rd = q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (accept_o) mem_q[q.wr[PW-1:0]] <= push_data_i;
    end

    // R3: the stored count never exceeds the depth
    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= FULL_LVL);

    // R5: the register logic never pops an empty ring
    a_r5_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && empty_o));

    // R12: push with pop on a full ring keeps it full
    a_r12_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && full_o && !clr_i) |=> full_o);

endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat #(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_i,
    input  logic          rd_clr_i,
    output logic [NB-1:0] errs_o
);

    typedef struct packed {
        logic [NB-1:0] bits;
    } err_t;

    err_t q, d;

    always_comb begin
        d = q;
        if (rd_clr_i) d.bits = '0;
        d.bits = d.bits | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign errs_o = q.bits;

    // R10: a clearing read with nothing new leaves all bits clear
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && set_i == '0) |=> errs_o == '0);

    // R10: a raised flag is visible on the next cycle, even across a clearing read
    a_r10_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((errs_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_par_err,
    input  logic        rx_frm_err,
    input  logic        rx_break,
    output logic        rx_evt,
    output logic        err_evt,
    output logic        tx_flush
);

    localparam int LW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic       en;
        logic [7:0] hold;
        logic       hold_vld;
    } ctl_t;

    ctl_t q, d;

    logic          wr_ctrl, rd_data_sel, rd_errs_sel;
    logic          rx_clr, incoming;
    logic [7:0]    in_byte;
    logic          fifo_push, fifo_pop, underflow, dropped, byp_load;
    logic          ring_accept, ring_full, ring_empty;
    logic [7:0]    ring_head;
    logic [LW-1:0] ring_level;
    logic [ERR_NB-1:0] err_set, errs;
    logic          ready;
    logic          unused_wdata;

    assign unused_wdata = ^reg_wdata[31:3];

    assign wr_ctrl     = reg_wr && (reg_addr == RG_CTRL);
    assign rd_data_sel = reg_rd && (reg_addr == RG_RDATA);
    assign rd_errs_sel = reg_rd && (reg_addr == RG_ERRS);

    assign rx_clr   = wr_ctrl && reg_wdata[CTL_RXCLR];
    assign tx_flush = wr_ctrl && reg_wdata[CTL_TXCLR];

    assign incoming = rx_valid || rx_break;
    assign in_byte  = rx_break ? 8'h00 : rx_byte;

    assign fifo_push = q.en && incoming;
    assign fifo_pop  = rd_data_sel && q.en && !ring_empty;
    assign underflow = rd_data_sel && q.en && ring_empty;
    assign dropped   = fifo_push && !rx_clr && !ring_accept;
    assign byp_load  = !q.en && incoming;

    assign rx_evt  = ring_accept || byp_load;
    assign err_evt = dropped || underflow;

    always_comb begin
        err_set          = '0;
        err_set[ERR_OVR] = dropped;
        err_set[ERR_PAR] = rx_valid && !rx_break && rx_par_err;
        err_set[ERR_FRM] = rx_valid && !rx_break && rx_frm_err;
        err_set[ERR_BRK] = rx_break;
    end

    rxq_ring #(
        .DEPTH (DEPTH),
        .DW    (8)
    ) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (rx_clr),
        .push_i      (fifo_push),
        .push_data_i (in_byte),
        .pop_i       (fifo_pop),
        .accept_o    (ring_accept),
        .head_o      (ring_head),
        .level_o     (ring_level),
        .full_o      (ring_full),
        .empty_o     (ring_empty)
    );

    rxq_errstat #(
        .NB (ERR_NB)
    ) u_errs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (err_set),
        .rd_clr_i (rd_errs_sel),
        .errs_o   (errs)
    );

    assign ready = q.en ? !ring_empty : q.hold_vld;

    always_comb begin
        d = q;
        if (wr_ctrl) d.en = reg_wdata[CTL_EN];
        if (byp_load) begin
            d.hold     = in_byte;
            d.hold_vld = 1'b1;
        end else if (rd_data_sel && !q.en) begin
            d.hold_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RG_CTRL:  reg_rdata[CTL_EN] = q.en;
            RG_XSTAT: reg_rdata[0]      = ready;
            RG_ERRS:  reg_rdata[ERR_NB-1:0] = errs;
            RG_FSTAT: reg_rdata = ring_full ? (32'd1 << FST_FULL) : 32'(ring_level);
            RG_RDATA: reg_rdata[7:0] = q.en ? (ring_empty ? 8'h00 : ring_head) : q.hold;
            default:  reg_rdata = '0;
        endcase
    end

    // R2: a receive clear leaves the FIFO empty on the next cycle
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> ring_empty);

    // R6: a bypass load is reported as ready on the next cycle
    a_r6_bypass_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_load && !wr_ctrl) |=> ready);

    // R8: a dropped byte never counts as stored
    a_r8_drop_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |-> !rx_evt);

    // R7: a drop on a full FIFO leaves it full
    a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped && !fifo_pop) |=> ring_full);

endmodule

// File: tb/uart_rxq_test.sv
module uart_rxq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_par_err = 1'b0;
    logic        rx_frm_err = 1'b0;
    logic        rx_break = 1'b0;
    logic        rx_evt, err_evt, tx_flush;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_XST = 3'd1, A_ERR = 3'd2,
                           A_FST = 3'd3, A_DAT = 3'd4;

    always #10 clk = ~clk;

    uart_rxq #(.DEPTH(16)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_break(rx_break), .rx_evt(rx_evt),
        .err_evt(err_evt), .tx_flush(tx_flush)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v, output logic fl);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        #1 fl = tx_flush;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v, output logic ee);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata; ee = err_evt;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx(input logic [7:0] b, input logic par, input logic frm,
                      input logic brk, output logic re, output logic ee);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_par_err = par; rx_frm_err = frm; rx_break = brk;
        #1 re = rx_evt; ee = err_evt;
        @(negedge clk);
        rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0; rx_break = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v; logic e;
        rd(A_CTRL, v, e); chk("R1 ctrl", v, 32'h0);
        rd(A_XST, v, e);  chk("R1 xstat", v, 32'h0);
        rd(A_ERR, v, e);  chk("R1 errs", v, 32'h0);
        rd(A_FST, v, e);  chk("R1 fstat", v, 32'h0);
    endtask

    task automatic t_bypass();
        logic [31:0] v; logic e, r;
        rx(8'hA5, 0, 0, 0, r, e); chk("R8 bypass rx_evt", {31'b0, r}, 1);
        rx(8'h3C, 0, 0, 0, r, e);
        rd(A_XST, v, e); chk("R6 ready set", v, 1);
        rd(A_DAT, v, e); chk("R6 held byte replaced", v, 32'h3C);
        rd(A_XST, v, e); chk("R6 ready cleared", v, 0);
    endtask

    task automatic t_fifo_basic();
        logic [31:0] v; logic e, r, f;
        wr(A_CTRL, 32'h1, f);
        rd(A_CTRL, v, e); chk("R2 enable bit", v, 1);
        rx(8'h11, 0, 0, 0, r, e); chk("R8 fifo rx_evt", {31'b0, r}, 1);
        rx(8'h22, 0, 0, 0, r, e);
        rx(8'h33, 0, 0, 0, r, e);
        rd(A_FST, v, e); chk("R3 count 3", v, 3);
        rd(A_DAT, v, e); chk("R4 first", v, 32'h11);
        rd(A_XST, v, e); chk("R4 ready remains", v, 1);
        rd(A_DAT, v, e); chk("R4 second", v, 32'h22);
        rd(A_DAT, v, e); chk("R4 third", v, 32'h33);
        rd(A_XST, v, e); chk("R4 ready clear", v, 0);
    endtask

    task automatic t_underflow();
        logic [31:0] v; logic e;
        rd(A_DAT, v, e);
        chk("R5 empty read data", v, 0);
        chk("R5 err_evt", {31'b0, e}, 1);
        rd(A_FST, v, e); chk("R5 still empty", v, 0);
    endtask

    task automatic fill16();
        logic e, r;
        for (int i = 0; i < 16; i++) rx(8'h40 + 8'(i), 0, 0, 0, r, e);
    endtask

    task automatic t_overflow();
        logic [31:0] v; logic e, r;
        fill16();
        rd(A_FST, v, e); chk("R3 full reads 0x100", v, 32'h100);
        rx(8'hEE, 0, 0, 0, r, e);
        chk("R7 drop err_evt", {31'b0, e}, 1);
        chk("R8 no rx_evt on drop", {31'b0, r}, 0);
        rd(A_XST, v, e); chk("R7 ready stays", v, 1);
        rd(A_ERR, v, e); chk("R7 overrun bit", v, 1);
        rd(A_ERR, v, e); chk("R10 cleared by read", v, 0);
        for (int i = 0; i < 16; i++) begin
            rd(A_DAT, v, e); chk("R7 contents intact", v, 32'h40 + i);
        end
    endtask

    task automatic t_clear();
        logic [31:0] v; logic e, r, f;
        rx(8'h01, 0, 0, 0, r, e);
        rx(8'h02, 0, 0, 0, r, e);
        wr(A_CTRL, 32'h5, f); chk("R2 tx_flush pulse", {31'b0, f}, 1);
        rd(A_FST, v, e); chk("R2 tx flush keeps rx", v, 2);
        wr(A_CTRL, 32'h3, f); chk("R2 no tx_flush", {31'b0, f}, 0);
        rd(A_CTRL, v, e); chk("R2 self-clear bits", v, 1);
        rd(A_FST, v, e); chk("R2 rx emptied", v, 0);
    endtask

    task automatic t_break();
        logic [31:0] v; logic e, r;
        rx(8'h77, 0, 0, 1, r, e); chk("R9 break stored", {31'b0, r}, 1);
        rd(A_FST, v, e); chk("R9 one byte only", v, 1);
        rd(A_ERR, v, e); chk("R9 break bit", v, 32'h8);
        rd(A_DAT, v, e); chk("R9 null byte", v, 0);
    endtask

    task automatic t_errbits();
        logic [31:0] v; logic e, r;
        rx(8'h10, 0, 1, 0, r, e);
        // clearing read of error status in the same cycle as a parity error
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = A_ERR;
        rx_valid = 1'b1; rx_byte = 8'h20; rx_par_err = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; rx_valid = 1'b0; rx_par_err = 1'b0;
        chk("R10 frame bit", v, 32'h4);
        rd(A_ERR, v, e); chk("R10 parity kept over clear", v, 32'h2);
        rd(A_DAT, v, e); rd(A_DAT, v, e); chk("R10 drained", v, 32'h20);
    endtask

    task automatic t_readonly();
        logic [31:0] v; logic e, r, f;
        rx(8'h5A, 0, 0, 0, r, e);
        wr(A_XST, 32'hFFFF_FFFF, f);
        wr(A_ERR, 32'hFFFF_FFFF, f);
        wr(A_FST, 32'hFFFF_FFFF, f);
        wr(A_DAT, 32'hFFFF_FFFF, f);
        rd(A_FST, v, e); chk("R11 count unchanged", v, 1);
        rd(A_XST, v, e); chk("R11 ready unchanged", v, 1);
        rd(A_ERR, v, e); chk("R11 errs unchanged", v, 0);
        rd(A_DAT, v, e); chk("R11 data unchanged", v, 32'h5A);
    endtask

    task automatic t_simul();
        logic [31:0] v; logic e, r, ee;
        rx(8'h61, 0, 0, 0, r, e);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = A_DAT; rx_valid = 1'b1; rx_byte = 8'h62;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; rx_valid = 1'b0;
        chk("R12 pop value", v, 32'h61);
        rd(A_FST, v, e); chk("R12 count unchanged", v, 1);
        rd(A_DAT, v, e); chk("R12 pushed byte", v, 32'h62);
        fill16();
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = A_DAT; rx_valid = 1'b1; rx_byte = 8'h99;
        #1 v = reg_rdata; r = rx_evt; ee = err_evt;
        @(negedge clk);
        reg_rd = 1'b0; rx_valid = 1'b0;
        chk("R12 full pop value", v, 32'h40);
        chk("R12 accepted when full", {30'b0, r, ee}, 32'h2);
        rd(A_FST, v, e); chk("R12 still full", v, 32'h100);
        for (int i = 1; i < 16; i++) rd(A_DAT, v, e);
        chk("R12 last old byte", v, 32'h4F);
        rd(A_DAT, v, e); chk("R12 new byte last", v, 32'h99);
        rd(A_FST, v, e); chk("R12 empty after drain", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_fifo_basic();
        t_underflow();
        t_overflow();
        t_clear();
        t_break();
        t_errbits();
        t_readonly();
        t_simul();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule